// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block lives on the device side of an asynchronous DRAM strobe interface. A fast local clock oversamples the active-low row strobe, column strobe and write enable. The block works out which kind of memory cycle the host is running from the order in which those strobes change. It reports each decoded cycle as a one-clock code. It also captures the row and column addresses, returns the row being refreshed, and drives read data with an output-enable flag.

The block holds a 10-bit refresh row counter for refreshes that use the column-strobe-first order. It also keeps a latched parallel test flag. While that flag is set, a read returns a single compare result, copied to every data bit, that tells whether the eight internal cell bits agree. The flag also forces certain address bits to zero. The memory array and the analog timing of the strobes are not part of this block.

Top module: `dram_cycle_decoder`

## Requirements
- R1: Each strobe passes through two synchronizing flops and then an edge detector. A decoded cycle code appears on `cyc_code` during the third clock after the strobe change, lasts one clock, and then returns to 0 (idle). Reset sets the code, `test_mode`, `dq_oe`, the captured addresses and the refresh counter to zero.
- R2: A row strobe fall with the column strobe high captures `row_addr`. Each later column strobe fall during the same row-strobe-low period captures `col_addr` and reports code 1 (read) when write enable is high, or code 2 (write) when it is low. Repeated column strobes give one code each.
- R3: If the row strobe rises with no column strobe fall since activation, the cycle reports code 3 (row-only refresh), and `refresh_row` equals the low 10 bits of the captured row.
- R4: If the column strobe is already low when the row strobe falls and write enable is high, the cycle reports code 4 (counter refresh). `refresh_row` shows the counter value, and the address pins leave `row_addr` unchanged.
- R5: The refresh counter starts at 0 and advances by one after each code 4, 5 or 6 cycle. It wraps from 1023 to 0.
- R6: If the column strobe is low and write enable is low when the row strobe falls, the cycle reports code 5 (test entry) and sets `test_mode`. The flag stays set through later read and write cycles.
- R7: `test_mode` is cleared by a row-only refresh, or by a counter refresh with write enable high.
- R8: Outside test mode, `dq_out` equals `cell_bits`. In test mode, `dq_out` is all ones when all eight cell bits are equal and all zeros otherwise.
- R9: In test mode, bit 10 of a captured row and bits 10 and 0 of a captured column read as zero.
- R10: Hidden refresh: the column strobe stays low after a read while the row strobe rises, and then the row strobe falls again. This reports code 6, refreshes the counter row, keeps `dq_oe` high until the column strobe rises, and leaves `test_mode` unchanged.
- R11: `dq_oe` rises with a read code and falls when the column strobe rises. A write code leaves it low.
- R12: Code 7 (error) is reported in three cases, each when both edges land in the same sample: the row and column strobes fall together from idle; the row strobe rises as the column strobe falls after activation; or the row strobe falls as the column strobe rises during a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Multiplexed address pins |
| cell_bits | input | 8 | Internal data bits at the addressed location |
| cyc_code | output | 3 | One-clock decoded cycle code |
| row_addr | output | 11 | Captured row address |
| col_addr | output | 11 | Captured column address |
| refresh_row | output | 10 | Row refreshed by the latest refresh cycle |
| test_mode | output | 1 | Latched parallel test flag |
| dq_oe | output | 1 | Read data output enable |
| dq_out | output | 8 | Read data or test compare result |

## Verification
The assertions assume that each strobe level lasts at least two clocks, so no edge is lost in the synchronizers. They also assume that the address pins are stable while a strobe edge passes through the synchronizers. The stimulus changes the inputs only on falling clock edges and then holds them for three full clocks. Edges meant to be simultaneous are driven in the same step. The bench uses same-sample edges only to provoke the error code.

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] cell_bits,
  output logic [2:0]    cyc_code,
  output logic [AW-1:0] row_addr,
  output logic [AW-1:0] col_addr,
  output logic [RW-1:0] refresh_row,
  output logic          test_mode,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out
);
  localparam logic [2:0] C_IDLE = 3'd0, C_READ = 3'd1, C_WRITE = 3'd2, C_ROWREF = 3'd3,
                         C_CTRREF = 3'd4, C_TEST = 3'd5, C_HIDDEN = 3'd6, C_ERR = 3'd7;

  typedef enum logic [2:0] {ST_IDLE, ST_ROW, ST_COL, ST_HOLD, ST_WAIT} st_t;
  st_t st;

  logic [2:0]    ras_sh, cas_sh;
  logic [1:0]    we_sh;
  logic [AW-1:0] addr_d1, addr_d2;
  logic [RW-1:0] rcnt;

  wire ras_s = ras_sh[1];
  wire cas_s = cas_sh[1];
  wire we_s  = we_sh[1];
  wire ras_fall = ras_sh[2] & ~ras_s;
  wire ras_rise = ~ras_sh[2] & ras_s;
  wire cas_fall = cas_sh[2] & ~cas_s;
  wire cas_rise = ~cas_sh[2] & cas_s;

  wire [AW-1:0] row_in = test_mode ? {1'b0, addr_d2[AW-2:0]} : addr_d2;
  wire [AW-1:0] col_in = test_mode ? {1'b0, addr_d2[AW-2:1], 1'b0} : addr_d2;

  wire bits_equal = (&cell_bits) | ~(|cell_bits);
  assign dq_out = test_mode ? {DW{bits_equal}} : cell_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_sh      <= '1;
      cas_sh      <= '1;
      we_sh       <= '1;
      addr_d1     <= '0;
      addr_d2     <= '0;
      st          <= ST_IDLE;
      cyc_code    <= C_IDLE;
      row_addr    <= '0;
      col_addr    <= '0;
      refresh_row <= '0;
      rcnt        <= '0;
      test_mode   <= 1'b0;
      dq_oe       <= 1'b0;
    end else begin
      ras_sh   <= {ras_sh[1:0], ras_n};
      cas_sh   <= {cas_sh[1:0], cas_n};
      we_sh    <= {we_sh[0], we_n};
      addr_d1  <= addr;
      addr_d2  <= addr_d1;
      cyc_code <= C_IDLE;
      if (cas_rise) dq_oe <= 1'b0;
      case (st)
        ST_IDLE: if (ras_fall) begin
          if (cas_fall) begin
            cyc_code <= C_ERR;
            st       <= ST_WAIT;
          end else if (!cas_s) begin
            cyc_code    <= we_s ? C_CTRREF : C_TEST;
            test_mode   <= !we_s;
            refresh_row <= rcnt;
            rcnt        <= rcnt + 1'b1;
            st          <= ST_WAIT;
          end else begin
            row_addr <= row_in;
            st       <= ST_ROW;
          end
        end
        ST_ROW: if (ras_rise) begin
          if (cas_fall) cyc_code <= C_ERR;
          else begin
            cyc_code    <= C_ROWREF;
            refresh_row <= row_addr[RW-1:0];
            test_mode   <= 1'b0;
          end
          st <= ST_IDLE;
        end else if (cas_fall) begin
          col_addr <= col_in;
          cyc_code <= we_s ? C_READ : C_WRITE;
          dq_oe    <= we_s;
          st       <= ST_COL;
        end
        ST_COL: if (ras_rise) begin
          st <= cas_s ? ST_IDLE : ST_HOLD;
        end else if (cas_fall) begin
          col_addr <= col_in;
          cyc_code <= we_s ? C_READ : C_WRITE;
          dq_oe    <= we_s;
        end
        ST_HOLD: if (ras_fall) begin
          if (cas_rise) cyc_code <= C_ERR;
          else begin
            cyc_code    <= C_HIDDEN;
            refresh_row <= rcnt;
            rcnt        <= rcnt + 1'b1;
          end
          st <= ST_WAIT;
        end else if (cas_rise) begin
          st <= ST_IDLE;
        end
        ST_WAIT: if (ras_rise) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_code == C_CTRREF || cyc_code == C_TEST || cyc_code == C_HIDDEN)
      |-> rcnt == RW'(refresh_row + 1'b1));
  assert_test_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_code == C_TEST |-> test_mode);
  assert_test_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_code == C_CTRREF || cyc_code == C_ROWREF) |-> !test_mode);
  assert_hidden_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_code == C_HIDDEN |-> (test_mode == $past(test_mode)) && dq_oe == $past(dq_oe));
  assert_read_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_code == C_READ |-> dq_oe);
  assert_write_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_code == C_WRITE |-> !dq_oe);
  assert_col_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && (cyc_code == C_READ || cyc_code == C_WRITE)) |-> !col_addr[0] && !col_addr[AW-1]);
  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_code != C_IDLE |=> cyc_code == C_IDLE);
endmodule

// File: tb/dram_cycle_decoder_bench.sv
`timescale 1ns/1ps
module dram_cycle_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0] cell_bits = '0;
  logic [2:0] cyc_code;
  logic [10:0] row_addr, col_addr;
  logic [9:0] refresh_row;
  logic test_mode, dq_oe;
  logic [7:0] dq_out;
  int checks = 0, errors = 0, rc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_cycle_decoder u_dram_cycle_decoder (.*);

  // {ras_n, cas_n, we_n, addr, expected code}
  localparam int NV = 38;
  localparam logic [16:0] VEC [NV] = '{
    {3'b111, 11'h000, 3'd0}, {3'b011, 11'h155, 3'd0}, {3'b001, 11'h0AA, 3'd1},
    {3'b011, 11'h0AA, 3'd0}, {3'b000, 11'h033, 3'd2}, {3'b011, 11'h033, 3'd0},
    {3'b111, 11'h000, 3'd0}, {3'b011, 11'h2F0, 3'd0}, {3'b111, 11'h2F0, 3'd3},
    {3'b101, 11'h000, 3'd0}, {3'b001, 11'h7FF, 3'd4}, {3'b101, 11'h7FF, 3'd0},
    {3'b111, 11'h000, 3'd0}, {3'b100, 11'h000, 3'd0}, {3'b000, 11'h000, 3'd5},
    {3'b100, 11'h000, 3'd0}, {3'b111, 11'h000, 3'd0}, {3'b011, 11'h123, 3'd0},
    {3'b001, 11'h456, 3'd1}, {3'b101, 11'h456, 3'd0}, {3'b001, 11'h000, 3'd6},
    {3'b101, 11'h000, 3'd0}, {3'b111, 11'h000, 3'd0}, {3'b001, 11'h000, 3'd7},
    {3'b101, 11'h000, 3'd0}, {3'b111, 11'h000, 3'd0}, {3'b101, 11'h000, 3'd0},
    {3'b001, 11'h000, 3'd4}, {3'b101, 11'h000, 3'd0}, {3'b111, 11'h000, 3'd0},
    {3'b011, 11'h000, 3'd0}, {3'b101, 11'h000, 3'd7}, {3'b111, 11'h000, 3'd0},
    {3'b011, 11'h000, 3'd0}, {3'b001, 11'h000, 3'd1}, {3'b101, 11'h000, 3'd0},
    {3'b011, 11'h000, 3'd7}, {3'b111, 11'h000, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic w, input logic [10:0] a);
    ras_n = r; cas_n = c; we_n = w; addr = a;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string req_of(input logic [2:0] code);
    case (code)
      3'd1, 3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R6";
      3'd6: return "R10";
      3'd7: return "R12";
      default: return "R1";
    endcase
  endfunction

  task automatic ctr_refresh();
    step(1, 0, 1, 11'h0FF);
    step(0, 0, 1, 11'h0FF);
    chk(cyc_code == 3'd4, "R4", cyc_code, 4);
    chk(refresh_row == 10'(rc), "R5", refresh_row, rc);
    rc = (rc + 1) % 1024;
    step(1, 0, 1, 11'h0FF);
    step(1, 1, 1, 11'h0FF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cyc_code == 3'd0, "R1", cyc_code, 0);
    chk(test_mode == 1'b0, "R1", test_mode, 0);
    chk(dq_oe == 1'b0, "R1", dq_oe, 0);
    chk(row_addr == 11'h0 && col_addr == 11'h0, "R1", row_addr, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:3]);
      chk(cyc_code == VEC[i][2:0], req_of(VEC[i][2:0]), cyc_code, VEC[i][2:0]);
      if (VEC[i][2:0] == 3'd3)
        chk(refresh_row == VEC[i][12:3], "R3", refresh_row, VEC[i][12:3]);
      if (VEC[i][2:0] >= 3'd4 && VEC[i][2:0] <= 3'd6) begin
        chk(refresh_row == 10'(rc), "R5", refresh_row, rc);
        rc++;
      end
    end
    chk(test_mode == 1'b0, "R7", test_mode, 0);

    // latency, pulse width, captures, output enable
    cell_bits = 8'h5A;
    step(0, 1, 1, 11'h3C5);
    cas_n = 1'b0; addr = 11'h1E7;
    repeat (2) @(posedge clk); @(negedge clk);
    chk(cyc_code == 3'd0, "R1", cyc_code, 0);
    @(posedge clk); @(negedge clk);
    chk(cyc_code == 3'd1, "R1", cyc_code, 1);
    chk(row_addr == 11'h3C5, "R2", row_addr, 11'h3C5);
    chk(col_addr == 11'h1E7, "R2", col_addr, 11'h1E7);
    chk(dq_oe == 1'b1, "R11", dq_oe, 1);
    chk(dq_out == 8'h5A, "R8", dq_out, 8'h5A);
    @(posedge clk); @(negedge clk);
    chk(cyc_code == 3'd0, "R1", cyc_code, 0);
    chk(dq_oe == 1'b1, "R11", dq_oe, 1);
    step(0, 1, 1, 11'h1E7);
    chk(dq_oe == 1'b0, "R11", dq_oe, 0);
    step(1, 1, 1, 11'h000);

    // address pins ignored in counter refresh
    ctr_refresh();
    chk(row_addr == 11'h3C5, "R4", row_addr, 11'h3C5);

    // test mode entry, masking, compare output
    step(1, 0, 0, 11'h000);
    step(0, 0, 0, 11'h000);
    chk(cyc_code == 3'd5 && test_mode, "R6", {cyc_code, test_mode}, {3'd5, 1'b1});
    rc++;
    step(1, 0, 1, 11'h000);
    step(1, 1, 1, 11'h000);
    step(0, 1, 1, 11'h7FF);
    step(0, 0, 1, 11'h7FF);
    chk(row_addr == 11'h3FF, "R9", row_addr, 11'h3FF);
    chk(col_addr == 11'h3FE, "R9", col_addr, 11'h3FE);
    cell_bits = 8'hFF; #1;
    chk(dq_out == 8'hFF, "R8", dq_out, 8'hFF);
    cell_bits = 8'h00; #1;
    chk(dq_out == 8'hFF, "R8", dq_out, 8'hFF);
    cell_bits = 8'h10; #1;
    chk(dq_out == 8'h00, "R8", dq_out, 8'h00);
    step(0, 1, 1, 11'h000);
    step(0, 0, 0, 11'h001);
    chk(cyc_code == 3'd2 && dq_oe == 1'b0, "R11", {cyc_code, dq_oe}, {3'd2, 1'b0});
    chk(test_mode == 1'b1, "R6", test_mode, 1);
    step(0, 1, 1, 11'h000);
    step(1, 1, 1, 11'h000);

    // hidden refresh keeps output and test flag
    step(0, 1, 1, 11'h010);
    step(0, 0, 1, 11'h020);
    step(1, 0, 1, 11'h000);
    chk(dq_oe == 1'b1, "R10", dq_oe, 1);
    step(0, 0, 1, 11'h000);
    chk(cyc_code == 3'd6, "R10", cyc_code, 6);
    chk(dq_oe == 1'b1 && test_mode == 1'b1, "R10", {dq_oe, test_mode}, 2'b11);
    chk(refresh_row == 10'(rc), "R5", refresh_row, rc);
    rc++;
    step(1, 0, 1, 11'h000);
    chk(dq_oe == 1'b1, "R10", dq_oe, 1);
    step(1, 1, 1, 11'h000);
    chk(dq_oe == 1'b0, "R11", dq_oe, 0);

    // row-only refresh clears test flag
    step(0, 1, 1, 11'h0C3);
    step(1, 1, 1, 11'h0C3);
    chk(cyc_code == 3'd3 && refresh_row == 10'h0C3, "R3", refresh_row, 10'h0C3);
    chk(test_mode == 1'b0, "R7", test_mode, 0);
    cell_bits = 8'h10; #1;
    chk(dq_out == 8'h10, "R8", dq_out, 8'h10);

    // counter wrap
    while (rc != 0) ctr_refresh();
    chk(rc == 0, "R5", rc, 0);
    ctr_refresh();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule